// File: doc/BRIEF.md
# ECC Error Event Logger

This block sits beside the ECC checker of a memory controller and keeps a record of the single-bit (corrected) and double-bit (uncorrected) error events that the checker reports. Each event arrives as a one-cycle pulse together with the failing address, the check syndrome and the physical rank. The block keeps a separate running count for each error class. It also keeps the details of the newest event in a capture stage that software cannot see.

Software services the block by polling a small register window. It reads the counters. It then writes a latch command, which copies the hidden capture into the detail registers. It reads the details and compares their type flags with the class it is servicing. Finally it clears the serviced counters by writing ones to the error register. Reads are combinational from the register address. Writes take effect on the clock edge on which the write strobe is high.

Top module: `ecc_err_log`

## Requirements
- R1: Reset clears both counters, the hidden capture and all detail registers. After reset, every register reads 0.
- R2: The counter register at 0x340 holds the single-bit count in bits 15:0 and the double-bit count in bits 31:16. Each error pulse adds one to its own class, and both classes count when both pulses arrive together.
- R3: A counter that holds 0xFFFF stays at 0xFFFF on further errors and does not wrap.
- R4: Writing 1 to bit 0 of the error register at 0x348 clears the single-bit count, and writing 1 to bit 16 clears the double-bit count. Zero bits have no effect. An error of that class in the same cycle as its clear leaves the count at 1.
- R5: Reading the error register returns bit 0 set when the single-bit count is nonzero and bit 16 set when the double-bit count is nonzero. All other bits read 0.
- R6: Every error pulse overwrites the hidden capture, so the capture always holds the newest event of either class. When both pulses arrive in one cycle, the event is captured as a double-bit error. None of this shows in the detail registers until a latch command.
- R7: A write with bit 24 set to the latch register at 0x354 copies the hidden capture into the detail registers on that edge. An event arriving in the same cycle as the latch is not part of that copy.
- R8: The detail registers keep their values until the next latch command, whatever errors arrive in between.
- R9: The syndrome register at 0x35C reads bit 0 = latched error was double-bit, bit 1 = latched error was single-bit, and bits 25:16 = the 10-bit syndrome.
- R10: The info register at 0x364 returns the latched physical rank in bits 9:8. The latched address reads as its low 32 bits at 0x358 and its high 32 bits at 0x37C.
- R11: The latch register reads 0. Unmapped addresses and undefined bits read 0. Writes to the counter and detail registers, and writes to the latch register with bit 24 clear, change nothing.
- R12: The captured address has its low three bits forced to 0, so that it names the 8-byte data word that holds the error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sgl_err_i | input | 1 | Single-bit error pulse from the ECC checker |
| dbl_err_i | input | 1 | Double-bit error pulse from the ECC checker |
| err_addr_i | input | 64 | Address of the failing access |
| err_syn_i | input | 10 | Syndrome of the failing word |
| err_rank_i | input | 2 | Physical rank of the failing access |
| reg_addr_i | input | 12 | Register byte address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from reg_addr_i |

## Verification
Every piece of hidden state surfaces at the register port. A bad hidden capture only appears after the next latch command, so the bench latches after each kind of event and reads back all four detail registers. A counter that slips shows up in the counter read on the very next clock, and so does a clear or a latch that fires on the wrong write. Every register read is compared on every clock against a behavioural model, so the first cycle in which the design diverges is reported.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;

  // register window geometry
  localparam int REG_AW      = 12;
  localparam int REG_DW      = 32;
  localparam int CNT_SLOT    = 16;

  // event field widths
  localparam int EADDR_W     = 64;
  localparam int SYN_W       = 10;
  localparam int RANK_W      = 2;
  localparam int GRAIN_BYTES = 8;
  localparam int GRAIN_LSB   = $clog2(GRAIN_BYTES);

  // register byte offsets (decoded by software)
  localparam logic [REG_AW-1:0] OFF_COUNT  = 12'h340;
  localparam logic [REG_AW-1:0] OFF_CLEAR  = 12'h348;
  localparam logic [REG_AW-1:0] OFF_LATCH  = 12'h354;
  localparam logic [REG_AW-1:0] OFF_ADDRLO = 12'h358;
  localparam logic [REG_AW-1:0] OFF_SYND   = 12'h35C;
  localparam logic [REG_AW-1:0] OFF_INFO   = 12'h364;
  localparam logic [REG_AW-1:0] OFF_ADDRHI = 12'h37C;

  // bit positions inside registers
  localparam int CLR_SGL_BIT  = 0;
  localparam int CLR_DBL_BIT  = 16;
  localparam int LATCH_GO_BIT = 24;
  localparam int SYND_DBL_BIT = 0;
  localparam int SYND_SGL_BIT = 1;
  localparam int SYND_LSB     = 16;
  localparam int RANK_LSB     = 8;

  // one error event record
  typedef struct packed {
    logic                dbl;
    logic                sgl;
    logic [RANK_W-1:0]   rank;
    logic [SYN_W-1:0]    syn;
    logic [EADDR_W-1:0]  addr;
  } ecc_evt_t;

endpackage

// File: rtl/ecc_rst_sync.sv
module ecc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/ecc_sat_counter.sv
module ecc_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);

  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
  localparam logic [W-1:0] CNT_ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (clr_i) begin
      cnt_d  = inc_i ? CNT_ONE : '0;
      cnt_en = 1'b1;
    end else if (inc_i && (cnt_q != CNT_MAX)) begin
      cnt_d  = cnt_q + CNT_ONE;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  // R2: one error step adds exactly one
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !clr_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + CNT_ONE));

  // R3: a full counter never wraps
  a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !clr_i) |=> (cnt_q == CNT_MAX));

  // R4: clear lands on zero, or on one with a coincident error
  a_r4_clear_result: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == ($past(inc_i) ? CNT_ONE : '0)));

  // R4: without clear or error the count holds
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !inc_i) |=> $stable(cnt_q));

endmodule

// File: rtl/ecc_capture.sv
module ecc_capture
  import ecc_log_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sgl_i,
  input  logic                dbl_i,
  input  logic [EADDR_W-1:0]  addr_i,
  input  logic [SYN_W-1:0]    syn_i,
  input  logic [RANK_W-1:0]   rank_i,
  input  logic                latch_i,
  output ecc_evt_t            vis_o
);

  ecc_evt_t stg_q;
  ecc_evt_t stg_d;
  ecc_evt_t vis_q;
  logic     stg_en;
  logic     unused_addr_lsb;

  always_comb begin
    stg_en     = sgl_i | dbl_i;
    stg_d.dbl  = dbl_i;
    stg_d.sgl  = sgl_i & ~dbl_i;
    stg_d.rank = rank_i;
    stg_d.syn  = syn_i;
    stg_d.addr = {addr_i[EADDR_W-1:GRAIN_LSB], {GRAIN_LSB{1'b0}}};
  end

  assign unused_addr_lsb = ^addr_i[GRAIN_LSB-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else if (stg_en) begin
      stg_q <= stg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vis_q <= '0;
    end else if (latch_i) begin
      vis_q <= stg_q;
    end
  end

  assign vis_o = vis_q;

  // R7: latch copies the capture as it stood before the edge
  a_r7_latch_copy: assert property (@(posedge clk) disable iff (!rst_n)
    latch_i |=> (vis_q == $past(stg_q)));

  // R8: visible details hold between latch commands
  a_r8_vis_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_i |=> $stable(vis_q));

  // R6: a simultaneous pair is captured as double-bit
  a_r6_double_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (dbl_i && sgl_i) |=> (stg_q.dbl && !stg_q.sgl));

  // R9: never both type flags at once
  a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vis_q.dbl, vis_q.sgl}));

endmodule

// File: rtl/ecc_reg_port.sv
module ecc_reg_port
  import ecc_log_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [REG_AW-1:0] addr_i,
  input  logic              we_i,
  input  logic [REG_DW-1:0] wdata_i,
  input  logic [CNT_W-1:0]  sgl_cnt_i,
  input  logic [CNT_W-1:0]  dbl_cnt_i,
  input  ecc_evt_t          vis_i,
  output logic              clr_sgl_o,
  output logic              clr_dbl_o,
  output logic              latch_o,
  output logic [REG_DW-1:0] rdata_o
);

  logic hit_clear;
  logic hit_latch;
  logic unused_wdata;

  always_comb begin
    hit_clear = we_i && (addr_i == OFF_CLEAR);
    hit_latch = we_i && (addr_i == OFF_LATCH);
    clr_sgl_o = hit_clear && wdata_i[CLR_SGL_BIT];
    clr_dbl_o = hit_clear && wdata_i[CLR_DBL_BIT];
    latch_o   = hit_latch && wdata_i[LATCH_GO_BIT];
  end

  assign unused_wdata = ^wdata_i;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFF_COUNT: begin
        rdata_o[CNT_W-1:0]          = sgl_cnt_i;
        rdata_o[CNT_SLOT +: CNT_W]  = dbl_cnt_i;
      end
      OFF_CLEAR: begin
        rdata_o[CLR_SGL_BIT] = |sgl_cnt_i;
        rdata_o[CLR_DBL_BIT] = |dbl_cnt_i;
      end
      OFF_SYND: begin
        rdata_o[SYND_DBL_BIT]         = vis_i.dbl;
        rdata_o[SYND_SGL_BIT]         = vis_i.sgl;
        rdata_o[SYND_LSB +: SYN_W]    = vis_i.syn;
      end
      OFF_INFO: begin
        rdata_o[RANK_LSB +: RANK_W]   = vis_i.rank;
      end
      OFF_ADDRLO: begin
        rdata_o = vis_i.addr[REG_DW-1:0];
      end
      OFF_ADDRHI: begin
        rdata_o = vis_i.addr[EADDR_W-1:REG_DW];
      end
      default: begin
        rdata_o = '0;
      end
    endcase
  end

endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_log_pkg::*;
#(
  parameter int CNT_W       = CNT_SLOT,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sgl_err_i,
  input  logic                dbl_err_i,
  input  logic [EADDR_W-1:0]  err_addr_i,
  input  logic [SYN_W-1:0]    err_syn_i,
  input  logic [RANK_W-1:0]   err_rank_i,
  input  logic [REG_AW-1:0]   reg_addr_i,
  input  logic                reg_we_i,
  input  logic [REG_DW-1:0]   reg_wdata_i,
  output logic [REG_DW-1:0]   reg_rdata_o
);

  localparam int NCLASS = 2;
  localparam int CL_SGL = 0;
  localparam int CL_DBL = 1;

  logic             rst_sync_n;
  logic [NCLASS-1:0] cls_inc;
  logic [NCLASS-1:0] cls_clr;
  logic [CNT_W-1:0]  cls_cnt [NCLASS];
  logic              latch_go;
  ecc_evt_t          vis;

  ecc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  assign cls_inc[CL_SGL] = sgl_err_i;
  assign cls_inc[CL_DBL] = dbl_err_i;

  for (genvar g = 0; g < NCLASS; g++) begin : g_cls
    ecc_sat_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .inc_i (cls_inc[g]),
      .clr_i (cls_clr[g]),
      .cnt_o (cls_cnt[g])
    );
  end

  ecc_capture u_capture (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .sgl_i   (sgl_err_i),
    .dbl_i   (dbl_err_i),
    .addr_i  (err_addr_i),
    .syn_i   (err_syn_i),
    .rank_i  (err_rank_i),
    .latch_i (latch_go),
    .vis_o   (vis)
  );

  ecc_reg_port #(.CNT_W(CNT_W)) u_regs (
    .addr_i    (reg_addr_i),
    .we_i      (reg_we_i),
    .wdata_i   (reg_wdata_i),
    .sgl_cnt_i (cls_cnt[CL_SGL]),
    .dbl_cnt_i (cls_cnt[CL_DBL]),
    .vis_i     (vis),
    .clr_sgl_o (cls_clr[CL_SGL]),
    .clr_dbl_o (cls_clr[CL_DBL]),
    .latch_o   (latch_go),
    .rdata_o   (reg_rdata_o)
  );

  // R11: the latch register always reads back zero
  a_r11_latch_reads_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_addr_i == OFF_LATCH) |-> (reg_rdata_o == '0));

endmodule

// File: tb/test_ecc_err_log.sv
module test_ecc_err_log;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sgl_err, dbl_err;
  logic [63:0] err_addr;
  logic [9:0]  err_syn;
  logic [1:0]  err_rank;
  logic [11:0] reg_addr;
  logic        reg_we;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;

  int n_chk = 0;
  int n_err = 0;
  bit cmp_en = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ecc_err_log i_ecc_err_log (
    .clk(clk), .rst_n(rst_n),
    .sgl_err_i(sgl_err), .dbl_err_i(dbl_err),
    .err_addr_i(err_addr), .err_syn_i(err_syn), .err_rank_i(err_rank),
    .reg_addr_i(reg_addr), .reg_we_i(reg_we), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata)
  );

  // behavioural reference model
  int          m_cnt [2];
  bit          st_d, st_s, vi_d, vi_s;
  int          st_rank, st_syn, vi_rank, vi_syn;
  logic [63:0] st_addr, vi_addr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt[0] = 0; m_cnt[1] = 0;
      st_d = 0; st_s = 0; st_rank = 0; st_syn = 0; st_addr = '0;
      vi_d = 0; vi_s = 0; vi_rank = 0; vi_syn = 0; vi_addr = '0;
    end else begin
      bit go, c0, c1;
      go = reg_we && reg_addr == 12'h354 && reg_wdata[24];
      c0 = reg_we && reg_addr == 12'h348 && reg_wdata[0];
      c1 = reg_we && reg_addr == 12'h348 && reg_wdata[16];
      if (go) begin
        vi_d = st_d; vi_s = st_s; vi_rank = st_rank; vi_syn = st_syn; vi_addr = st_addr;
      end
      if (c0) m_cnt[0] = sgl_err ? 1 : 0;
      else if (sgl_err && m_cnt[0] < 65535) m_cnt[0]++;
      if (c1) m_cnt[1] = dbl_err ? 1 : 0;
      else if (dbl_err && m_cnt[1] < 65535) m_cnt[1]++;
      if (sgl_err || dbl_err) begin
        st_d = dbl_err; st_s = sgl_err && !dbl_err;
        st_rank = err_rank; st_syn = err_syn;
        st_addr = {err_addr[63:3], 3'b000};
      end
    end
  end

  function automatic logic [31:0] mread(input logic [11:0] a);
    logic [31:0] r = '0;
    case (a)
      12'h340: r = {m_cnt[1][15:0], m_cnt[0][15:0]};
      12'h348: begin r[0] = (m_cnt[0] != 0); r[16] = (m_cnt[1] != 0); end
      12'h35C: begin r[0] = vi_d; r[1] = vi_s; r[25:16] = vi_syn[9:0]; end
      12'h364: r[9:8] = vi_rank[1:0];
      12'h358: r = vi_addr[31:0];
      12'h37C: r = vi_addr[63:32];
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string tag_of(input logic [11:0] a);
    case (a)
      12'h340: return "R2";
      12'h348: return "R5";
      12'h35C: return "R9";
      12'h364, 12'h358, 12'h37C: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (cmp_en && !done) chk(tag_of(reg_addr), reg_rdata, mread(reg_addr));
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a; reg_we = 0;
    @(negedge clk);
    chk(tag, reg_rdata, exp);
    cyc();
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    cyc();
    reg_we = 0; reg_wdata = '0;
  endtask

  task automatic evt(input bit s, input bit d, input logic [63:0] ad,
                     input logic [9:0] sy, input logic [1:0] rk);
    sgl_err = s; dbl_err = d; err_addr = ad; err_syn = sy; err_rank = rk;
    cyc();
    sgl_err = 0; dbl_err = 0;
  endtask

  task automatic do_reset();
    cmp_en = 0;
    rst_n = 0;
    repeat (3) cyc();
    rst_n = 1;
    repeat (4) cyc();
    cmp_en = 1;
  endtask

  initial begin
    sgl_err = 0; dbl_err = 0; err_addr = '0; err_syn = '0; err_rank = '0;
    reg_addr = '0; reg_we = 0; reg_wdata = '0;
    do_reset();

    // R1: reset state
    rd(12'h340, 32'h0, "R1");
    rd(12'h348, 32'h0, "R1");
    rd(12'h35C, 32'h0, "R1");
    rd(12'h358, 32'h0, "R1");

    // R2: counting both classes
    repeat (3) evt(1, 0, 64'h1234_5678_9ABC_DEF5, 10'h2A5, 2'd2);
    repeat (2) evt(0, 1, 64'h0000_00FF_0000_1007, 10'h3FF, 2'd1);
    rd(12'h340, 32'h0002_0003, "R2");
    rd(12'h348, 32'h0001_0001, "R5");
    // R6: still hidden before a latch
    rd(12'h35C, 32'h0, "R6");

    // R7: latch, then decode fields
    wr(12'h354, 32'h0100_0000);
    rd(12'h35C, 32'h03FF_0001, "R9");
    rd(12'h364, 32'h0000_0100, "R10");
    rd(12'h358, 32'h0000_1000, "R12");
    rd(12'h37C, 32'h0000_00FF, "R10");

    // R8: new event does not show until latched
    evt(1, 0, 64'hA5A5_A5A5_5A5A_5A5F, 10'h155, 2'd3);
    rd(12'h35C, 32'h03FF_0001, "R8");
    wr(12'h354, 32'h0100_0000);
    rd(12'h35C, 32'h0155_0002, "R9");
    rd(12'h358, 32'h5A5A_5A58, "R12");
    rd(12'h364, 32'h0000_0300, "R10");

    // R6: simultaneous pulses -> both counted, captured as double
    evt(1, 1, 64'h10, 10'h0F0, 2'd0);
    wr(12'h354, 32'h0100_0000);
    rd(12'h35C, 32'h00F0_0001, "R6");
    rd(12'h340, 32'h0003_0005, "R2");

    // R7: event in same cycle as latch is not in that copy
    reg_addr = 12'h354; reg_wdata = 32'h0100_0000; reg_we = 1;
    evt(1, 0, 64'h40, 10'h001, 2'd1);
    reg_we = 0;
    rd(12'h35C, 32'h00F0_0001, "R7");
    wr(12'h354, 32'h0100_0000);
    rd(12'h35C, 32'h0001_0002, "R7");

    // R4: clears
    wr(12'h348, 32'h0000_0001);
    rd(12'h340, 32'h0003_0000, "R4");
    wr(12'h348, 32'h0000_0000);
    rd(12'h340, 32'h0003_0000, "R4");
    reg_addr = 12'h348; reg_wdata = 32'h0001_0000; reg_we = 1;
    evt(0, 1, 64'h80, 10'h002, 2'd0);
    reg_we = 0;
    rd(12'h340, 32'h0001_0000, "R4");
    rd(12'h348, 32'h0001_0000, "R5");

    // R11: read-only and undefined behaviour
    rd(12'h354, 32'h0, "R11");
    wr(12'h340, 32'hFFFF_FFFF);
    rd(12'h340, 32'h0001_0000, "R11");
    wr(12'h35C, 32'hFFFF_FFFF);
    rd(12'h35C, 32'h0001_0002, "R11");
    wr(12'h354, 32'h00FF_FFFF);
    rd(12'h35C, 32'h0001_0002, "R11");
    rd(12'h300, 32'h0, "R11");

    // R3: saturation
    sgl_err = 1; err_addr = 64'h8; err_syn = 10'h3; err_rank = 2'd2;
    repeat (65540) cyc();
    sgl_err = 0;
    rd(12'h340, 32'h0001_FFFF, "R3");
    evt(1, 0, 64'h8, 10'h3, 2'd2);
    rd(12'h340, 32'h0001_FFFF, "R3");

    // R1: reset mid-run
    do_reset();
    rd(12'h340, 32'h0, "R1");
    rd(12'h35C, 32'h0, "R1");
    rd(12'h37C, 32'h0, "R1");

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule